// File: doc/BRIEF.md
# Video Controller Register File with Interrupt Latch

This block is the processor-side register bank of a raster video controller. A 6-bit register offset, a write strobe with 8-bit data and a read strobe address a set of 47 byte-wide locations that hold the controller's position, control, color and enable settings. The pixel pipeline, the sprite fetch engine and the raster counter live elsewhere. They report to this block through single-cycle event inputs. Those inputs are a raster compare hit, a light-pen edge, and two 8-bit sprite collision masks: one for sprite against sprite and one for sprite against background.

Four event sources set bits in an interrupt latch. Software clears a latch bit by writing a 1 to it. The active-low interrupt output is held low for as long as a latched bit has its enable bit set. The two collision registers accumulate mask bits until the processor reads them, and the read clears them. A collision interrupt is raised only when a collision register leaves the all-zero state. Unimplemented locations and unimplemented bits read as ones. Because only six address bits are decoded, the bank repeats on every 64-byte boundary of the upstream window.

Top module: `vreg_file`

## Requirements
- R1: After a synchronous active-low reset, every stored bit, every latch bit and both collision registers are 0, and `irq_n` is 1.
- R2: Offsets 0 to 46, other than 25, 30 and 31, are storage. `rd_data` follows `reg_addr` combinationally and returns the written value in implemented bits and 1 in unimplemented bits. The unimplemented bits are offset 22 bits 7:6, offset 24 bit 0, offset 26 bits 7:4, and bits 7:4 of every offset from 32 to 46.
- R3: Offsets 47 to 63 read 0xFF, and writes to them change nothing.
- R4: Offset 25 reads the latch. Bit 0 is raster, bit 1 is sprite-background, bit 2 is sprite-sprite and bit 3 is light pen. Bits 6:4 read 1, and bit 7 reads 1 exactly when `irq_n` is low. Offset 26 holds the enable bits in the same positions.
- R5: A raster or light-pen pulse sets its latch bit at the clock edge that samples it. The bit then stays set until software clears it.
- R6: Writing offset 25 clears each latch bit written as 1 and leaves bits written as 0 unchanged. An event arriving in the same cycle as its clear leaves the bit set.
- R7: `irq_n` is registered. It goes low one cycle after (latch AND enable) becomes nonzero and returns high one cycle after that AND becomes zero.
- R8: Offset 30 (sprite-sprite) and offset 31 (sprite-background) are collision registers. Each cycle they OR in their mask input, and writes to them are ignored.
- R9: A read strobe at offset 30 or 31 returns the current value and clears that register at the same edge.
- R10: A collision latch bit is set only when the collision register is zero and the mask is nonzero. Zero here means the value left after any read clear in that cycle. Mask bits that arrive while the register is nonzero do not set the latch.
- R11: Mask bits that arrive in the cycle of a clearing read are kept. They appear in the register after the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 6 | Register offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe (clears collision registers) |
| rd_data | output | 8 | Read data for `reg_addr` |
| raster_evt | input | 1 | Raster compare hit pulse |
| pen_evt | input | 1 | Light-pen edge pulse |
| ss_mask | input | 8 | Sprite-sprite collision mask |
| sb_mask | input | 8 | Sprite-background collision mask |
| irq_n | output | 1 | Interrupt request, active low, registered |

## Verification
Some properties are checked on every cycle. Unimplemented offsets read as all ones. The interrupt output tracks the registered AND of latch and enable. A latch bit persists until a write-1 clears it. A clearing write with no competing event empties the bit. Collision bits are never lost except by a read. Other behaviour only the bench's scenarios can show: the per-offset masks of unimplemented bits, the zero-to-nonzero rule that gates collision interrupts, and the race cases. In those races a clear write meets a new event, or a collision read meets a new mask.

// File: rtl/vreg_pkg.sv
// Package: shared sizes, special offsets and the per-offset mask of
// implemented bits for the video register file.
// Assumes: 8-bit registers, 6-bit register offsets.
package vreg_pkg;
    localparam int DATA_W      = 8;
    localparam int ADDR_W      = 6;
    localparam int NUM_REGS    = 47;
    localparam int NUM_SRC     = 4;
    localparam int NUM_SPR     = 8;

    localparam int OFS_CTRL_B  = 22;
    localparam int OFS_MEMPTR  = 24;
    localparam int OFS_LATCH   = 25;
    localparam int OFS_ENABLE  = 26;
    localparam int OFS_COLL_SS = 30;
    localparam int OFS_COLL_SB = 31;
    localparam int OFS_COLOR   = 32;

    // Interrupt source bit positions (decoded by software)
    localparam int SRC_RASTER  = 0;
    localparam int SRC_SB      = 1;
    localparam int SRC_SS      = 2;
    localparam int SRC_PEN     = 3;

    // Mask of implemented bits for a storage offset
    function automatic logic [DATA_W-1:0] impl_mask(input int ofs);
        logic [DATA_W-1:0] m;
        m = '1;
        if (ofs == OFS_CTRL_B)       m = 8'h3F;
        else if (ofs == OFS_MEMPTR)  m = 8'hFE;
        else if (ofs == OFS_ENABLE)  m = 8'h0F;
        else if (ofs >= OFS_COLOR)   m = 8'h0F;
        return m;
    endfunction

    // True for offsets whose content is not plain storage
    function automatic logic is_special(input int ofs);
        return (ofs == OFS_LATCH) || (ofs == OFS_COLL_SS) || (ofs == OFS_COLL_SB);
    endfunction
endpackage

// File: rtl/vreg_store.sv
// Module: plain storage cells for the register bank. Each cell keeps only
// its implemented bits; special offsets are never written here.
// Assumes: write happens at the clock edge where wr_en is sampled high.
module vreg_store
    import vreg_pkg::*;
#(
    parameter int N_REGS = NUM_REGS,
    parameter int AW     = ADDR_W,
    parameter int DW     = DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [AW-1:0]      addr,
    input  logic [DW-1:0]      wdata,
    output logic [N_REGS*DW-1:0] cells
);
    for (genvar i = 0; i < N_REGS; i++) begin : g_cell
        localparam logic [DW-1:0] MASK     = DW'(impl_mask(i));
        localparam logic          WRITABLE = !is_special(i);
        logic [DW-1:0] cell_q;

        // Capture a write into this cell, implemented bits only
        always_ff @(posedge clk) begin
            if (!rst_n)
                cell_q <= '0;
            else if (WRITABLE && wr_en && (addr == AW'(i)))
                cell_q <= wdata & MASK;
        end

        assign cells[i*DW +: DW] = cell_q;
    end
endmodule

// File: rtl/vreg_coll.sv
// Module: one read-clear collision register. Mask bits are ORed in each
// cycle; a read clears the register but same-cycle mask bits survive.
// first_hit flags a transition out of the all-zero state.
module vreg_coll #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_clr,
    input  logic [W-1:0] evt_mask,
    output logic [W-1:0] coll_q,
    output logic         first_hit
);
    logic [W-1:0] base;

    // Value left after an optional read clear in this cycle
    always_comb begin
        base      = rd_clr ? '0 : coll_q;
        first_hit = (base == '0) && (evt_mask != '0);
    end

    // Accumulate collision bits
    always_ff @(posedge clk) begin
        if (!rst_n)
            coll_q <= '0;
        else
            coll_q <= base | evt_mask;
    end
endmodule

// File: rtl/vreg_irq.sv
// Module: interrupt latch with write-one-to-clear and a registered,
// active-low request output. A set in the same cycle as a clear wins.
module vreg_irq #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_bits,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_bits,
    input  logic [N-1:0] enable,
    output logic [N-1:0] latch_q,
    output logic         irq_n
);
    logic [N-1:0] latch_d;

    // Next latch: clear requested bits, then apply new events
    always_comb begin
        latch_d = (latch_q & ~(clr_wr ? clr_bits : '0)) | set_bits;
    end

    // Latch state
    always_ff @(posedge clk) begin
        if (!rst_n)
            latch_q <= '0;
        else
            latch_q <= latch_d;
    end

    // Registered request output, glitch free
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_n <= 1'b1;
        else
            irq_n <= ~|(latch_q & enable);
    end
endmodule

// File: rtl/vreg_file.sv
// Module: top of the video register file. Decodes a 6-bit offset, holds
// storage, interrupt latch/enable and two read-clear collision registers,
// and drives a combinational read port plus an active-low interrupt.
// Assumes: event inputs are synchronous single-cycle pulses or masks.
module vreg_file
    import vreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              raster_evt,
    input  logic              pen_evt,
    input  logic [NUM_SPR-1:0] ss_mask,
    input  logic [NUM_SPR-1:0] sb_mask,
    output logic              irq_n
);
    localparam int CELL_BITS = NUM_REGS * DATA_W;

    logic [CELL_BITS-1:0] cells;
    logic [NUM_SRC-1:0]   irq_latch;
    logic [NUM_SRC-1:0]   irq_enable;
    logic [NUM_SRC-1:0]   irq_set;
    logic [NUM_SPR-1:0]   coll_ss;
    logic [NUM_SPR-1:0]   coll_sb;
    logic                 ss_first;
    logic                 sb_first;
    logic                 rd_ss;
    logic                 rd_sb;
    logic                 clr_wr;
    logic [DATA_W-1:0]    plain;

    vreg_store #(.N_REGS(NUM_REGS), .AW(ADDR_W), .DW(DATA_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (reg_addr),
        .wdata (wr_data),
        .cells (cells)
    );

    // Decode strobes that touch special offsets
    always_comb begin
        rd_ss  = rd_en && (reg_addr == ADDR_W'(OFS_COLL_SS));
        rd_sb  = rd_en && (reg_addr == ADDR_W'(OFS_COLL_SB));
        clr_wr = wr_en && (reg_addr == ADDR_W'(OFS_LATCH));
    end

    vreg_coll #(.W(NUM_SPR)) u_coll_ss (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_clr    (rd_ss),
        .evt_mask  (ss_mask),
        .coll_q    (coll_ss),
        .first_hit (ss_first)
    );

    vreg_coll #(.W(NUM_SPR)) u_coll_sb (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_clr    (rd_sb),
        .evt_mask  (sb_mask),
        .coll_q    (coll_sb),
        .first_hit (sb_first)
    );

    // Gather interrupt sources in their bit positions
    always_comb begin
        irq_set             = '0;
        irq_set[SRC_RASTER] = raster_evt;
        irq_set[SRC_SB]     = sb_first;
        irq_set[SRC_SS]     = ss_first;
        irq_set[SRC_PEN]    = pen_evt;
        irq_enable          = cells[OFS_ENABLE*DATA_W +: NUM_SRC];
    end

    vreg_irq #(.N(NUM_SRC)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_bits (irq_set),
        .clr_wr   (clr_wr),
        .clr_bits (wr_data[NUM_SRC-1:0]),
        .enable   (irq_enable),
        .latch_q  (irq_latch),
        .irq_n    (irq_n)
    );

    // Select the storage cell addressed
    always_comb begin
        plain = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (reg_addr == ADDR_W'(i))
                plain = cells[i*DATA_W +: DATA_W];
        end
    end

    // Read data: special offsets, unused offsets, or masked storage
    always_comb begin
        if (int'(reg_addr) >= NUM_REGS)
            rd_data = '1;
        else if (reg_addr == ADDR_W'(OFS_LATCH))
            rd_data = {~irq_n, {(DATA_W-1-NUM_SRC){1'b1}}, irq_latch};
        else if (reg_addr == ADDR_W'(OFS_COLL_SS))
            rd_data = coll_ss;
        else if (reg_addr == ADDR_W'(OFS_COLL_SB))
            rd_data = coll_sb;
        else
            rd_data = plain | ~impl_mask(int'(reg_addr));
    end
endmodule

// File: rtl/vreg_file_chk.sv
// Checker: cycle-level properties of the register file, bound to the top.
module vreg_file_chk
    import vreg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              raster_evt,
    input logic [NUM_SPR-1:0] ss_mask,
    input logic              irq_n,
    input logic [NUM_SRC-1:0] irq_latch,
    input logic [NUM_SRC-1:0] irq_enable,
    input logic [NUM_SPR-1:0] coll_ss
);
    // R3: unused offsets read all ones
    a_r3_unused_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(reg_addr) >= NUM_REGS) |-> (rd_data == 8'hFF));

    // R7: request output follows registered latch AND enable
    a_r7_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_n == !(|($past(irq_latch) & $past(irq_enable)))));

    // R5: raster latch bit holds until a write-1 clear
    a_r5_latch_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_latch[SRC_RASTER] &&
         !(wr_en && reg_addr == ADDR_W'(OFS_LATCH) && wr_data[SRC_RASTER]))
        |=> irq_latch[SRC_RASTER]);

    // R6: write-1 clear with no competing event empties the bit
    a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr == ADDR_W'(OFS_LATCH) && wr_data[SRC_RASTER] && !raster_evt)
        |=> !irq_latch[SRC_RASTER]);

    // R8: collision bits are never lost without a read
    a_r8_coll_keep: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && reg_addr == ADDR_W'(OFS_COLL_SS))
        |=> ((coll_ss & $past(coll_ss)) == $past(coll_ss)));

    // R9: a read with no new mask empties the register
    a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_addr == ADDR_W'(OFS_COLL_SS) && ss_mask == '0)
        |=> (coll_ss == '0));
endmodule

bind vreg_file vreg_file_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .raster_evt (raster_evt),
    .ss_mask    (ss_mask),
    .irq_n      (irq_n),
    .irq_latch  (irq_latch),
    .irq_enable (irq_enable),
    .coll_ss    (coll_ss)
);

// File: tb/tb_vreg_file.sv
module tb_vreg_file;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [5:0] ofs;
        logic [7:0] wval;
        logic [7:0] rexp;
    } vec_t;

    // Write/read-back vectors (R2, R3, R8)
    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{6'd0,  8'hA5, 8'hA5},   // R2 full byte
        '{6'd16, 8'h81, 8'h81},   // R2
        '{6'd17, 8'h3B, 8'h3B},   // R2
        '{6'd22, 8'h00, 8'hC0},   // R2 bits 7:6 read 1
        '{6'd22, 8'h15, 8'hD5},   // R2
        '{6'd24, 8'h00, 8'h01},   // R2 bit 0 reads 1
        '{6'd26, 8'h00, 8'hF0},   // R2 enable upper nibble
        '{6'd32, 8'h37, 8'hF7},   // R2 color
        '{6'd46, 8'h0A, 8'hFA},   // R2 last color
        '{6'd47, 8'h12, 8'hFF},   // R3
        '{6'd63, 8'h00, 8'hFF},   // R3
        '{6'd30, 8'h55, 8'h00}    // R8 write ignored
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] reg_addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       raster_evt = 1'b0;
    logic       pen_evt = 1'b0;
    logic [7:0] ss_mask = '0;
    logic [7:0] sb_mask = '0;
    logic       irq_n;

    int n_checks = 0;
    int n_fails  = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vreg_file dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .raster_evt(raster_evt), .pen_evt(pen_evt), .ss_mask(ss_mask),
        .sb_mask(sb_mask), .irq_n(irq_n)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic peek(input logic [5:0] a, output logic [7:0] v);
        reg_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic do_read(input logic [5:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a; rd_en = 1'b1;
        #1;
        v = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse(input logic r, input logic p, input logic [7:0] ss, input logic [7:0] sb);
        @(negedge clk);
        raster_evt = r; pen_evt = p; ss_mask = ss; sb_mask = sb;
        @(negedge clk);
        raster_evt = 1'b0; pen_evt = 1'b0; ss_mask = '0; sb_mask = '0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        peek(6'd25, v); check("R1 latch", v, 8'h70);
        peek(6'd30, v); check("R1 coll ss", v, 8'h00);
        peek(6'd31, v); check("R1 coll sb", v, 8'h00);
        peek(6'd32, v); check("R1 color", v, 8'hF0);
        check("R1 irq_n", {7'd0, irq_n}, 8'h01);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            do_write(VECS[i].ofs, VECS[i].wval);
            peek(VECS[i].ofs, v);
            check("R2/R3/R8 vector", v, VECS[i].rexp);
        end

        // R5 raster sets latch, not enabled
        pulse(1'b1, 1'b0, 8'h00, 8'h00);
        peek(6'd25, v); check("R5 raster latch", v, 8'h71);
        @(negedge clk);
        check("R7 no enable irq_n", {7'd0, irq_n}, 8'h01);

        // R7 enable raster
        do_write(6'd26, 8'h01);
        @(negedge clk);
        check("R7 irq_n low", {7'd0, irq_n}, 8'h00);
        peek(6'd25, v); check("R4 bit7 set", v, 8'hF1);

        // R6 write 0 keeps, write 1 clears
        do_write(6'd25, 8'h0E);
        peek(6'd25, v); check("R6 zero no effect", v, 8'hF1);
        do_write(6'd25, 8'h01);
        @(negedge clk);
        check("R7 irq_n release", {7'd0, irq_n}, 8'h01);
        peek(6'd25, v); check("R6 cleared", v, 8'h70);

        // R6 event wins over same-cycle clear
        @(negedge clk);
        reg_addr = 6'd25; wr_data = 8'h01; wr_en = 1'b1; raster_evt = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; raster_evt = 1'b0;
        peek(6'd25, v); check("R6 race set wins", v[3:0], 4'h1);
        do_write(6'd25, 8'h01);

        // R10 first collision sets latch; read clears (R9)
        pulse(1'b0, 1'b0, 8'h03, 8'h00);
        peek(6'd25, v); check("R10 ss latch", v, 8'h74);
        do_read(6'd30, v); check("R9 read value", v, 8'h03);
        peek(6'd30, v); check("R9 cleared", v, 8'h00);
        do_write(6'd25, 8'h04);
        pulse(1'b0, 1'b0, 8'h10, 8'h00);
        do_write(6'd25, 8'h04);
        pulse(1'b0, 1'b0, 8'h20, 8'h00);
        peek(6'd30, v); check("R8 accumulate", v, 8'h30);
        peek(6'd25, v); check("R10 no relatch", v, 8'h70);

        // R11 mask during clearing read survives
        @(negedge clk);
        reg_addr = 6'd30; rd_en = 1'b1; ss_mask = 8'h08;
        #1; v = rd_data;
        check("R11 read old value", v, 8'h30);
        @(negedge clk);
        rd_en = 1'b0; ss_mask = 8'h00;
        peek(6'd30, v); check("R11 new bit kept", v, 8'h08);
        peek(6'd25, v); check("R10 latch after clear", v, 8'h74);
        do_write(6'd25, 8'h04);

        // Sprite-background and pen sources
        pulse(1'b0, 1'b0, 8'h00, 8'h80);
        peek(6'd31, v); check("R8 sb value", v, 8'h80);
        peek(6'd25, v); check("R10 sb latch", v, 8'h72);
        pulse(1'b0, 1'b1, 8'h00, 8'h00);
        peek(6'd25, v); check("R5 pen latch", v, 8'h7A);
        do_write(6'd26, 8'h0F);
        @(negedge clk);
        check("R7 all enabled", {7'd0, irq_n}, 8'h00);
        do_write(6'd31, 8'hFF);
        peek(6'd31, v); check("R8 sb write ignored", v, 8'h80);
        do_read(6'd31, v); check("R9 sb read", v, 8'h80);
        peek(6'd31, v); check("R9 sb cleared", v, 8'h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule